// File: doc/BRIEF.md
# Self-Timed Peripheral Reset Pulse Sequencer

This block is one reset channel for a single peripheral, controlled through a 32-bit register. Software writes the request bit to launch a reset pulse. The block then stops the peripheral clock and drives the reset line high for a programmed number of timing ticks. It drops the reset line and waits the same number of ticks while the clock is still stopped. It then lets the clock run again, clears the request bit by itself and sets a sticky done flag. Software clears that flag by writing 1 to it.

A tick is one quarter of a microsecond. A parameterised divider on the system clock produces it (`TICK_DIV` system cycles per tick). The 8-bit period field sets the tick count for each phase, so a phase lasts at most 255 ticks and a full sequence at most 510 ticks. A period of zero behaves as one tick. The register has no write-enable mask bits, so software updates it with a plain read-modify-write.

The controller runs through five named states:
- **IDLE**: clock running, reset low. A start write moves it to **GATE**.
- **GATE**: lasts one cycle with the clock stopped, then moves to **APPLY**.
- **APPLY**: reset high for N ticks, then moves to **RELEASE**.
- **RELEASE**: reset low and clock still stopped for N ticks, then moves to **UNGATE**.
- **UNGATE**: lasts one cycle with the clock running again, then returns to **IDLE** and sets done.

Top module: `rst_pulse_seq`

## Requirements
- R1: After reset, `rd_data` reads 0, `clk_en` is 1 and `per_rst` is 0.
- R2: A write with bit 0 = 1 while idle starts a sequence. From the next cycle `clk_en` is 0, and `per_rst` stays 0 for exactly one cycle (GATE) before it rises.
- R3: `per_rst` is high for exactly N*TICK_DIV consecutive cycles, where N is the period field, bits [23:16].
- R4: After `per_rst` falls, `clk_en` stays 0 for exactly N*TICK_DIV cycles. `clk_en` then returns to 1.
- R5: A period field of 0 gives each phase the length of one tick (TICK_DIV cycles).
- R6: Read bit 0 (request) is 1 from the cycle after the start write through the UNGATE cycle. In the following cycle it reads 0 and bit 4 (done) reads 1.
- R7: While a sequence runs, writes are ignored. A 1 or a 0 on bit 0 has no effect, a new period value is not stored, and no second sequence follows.
- R8: The done flag (bit 4) stays set until a write carries 1 in bit 4. A write with bit 4 = 0 leaves it set. If completion and a clearing write fall in the same cycle, done ends up set.
- R9: `per_rst` is never 1 while `clk_en` is 1.
- R10: Bits other than 0, 4 and [23:16] always read 0. A write with bit 0 = 0 while idle starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | 32 | Write data: bit 0 request, bit 4 done (write 1 to clear), [23:16] period |
| rd_data | output | 32 | Register read value, same layout as the write data |
| clk_en | output | 1 | Peripheral clock enable, 1 = clock running |
| per_rst | output | 1 | Active-high peripheral reset |

## Verification
The main sequence runs with a zero period, the maximum period 255, and a seeded random spread of periods. The zero case isolates the substitution of one tick for zero. The maximum case exposes any counter that is too narrow, and the random spread catches off-by-one errors in the tick count that a single value could hide. Directed runs add three cases:
- writes of both polarities during a running sequence, which separate "ignored" from "restarted" and from "cancelled";
- a done-clearing write in the completion cycle, which shows whether set or clear wins;
- a write of garbage to the unused bits, which shows that they read as zero.

// File: rtl/rps_pkg.sv
package rps_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_GATE,
        S_APPLY,
        S_RELEASE,
        S_UNGATE
    } seq_state_t;

    localparam int REQ_BIT  = 0;
    localparam int DONE_BIT = 4;
    localparam int PER_LSB  = 16;

endpackage

// File: rtl/rps_tick_div.sv
module rps_tick_div #(
    parameter int TICK_DIV = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);

    generate
        if (TICK_DIV <= 1) begin : g_pass
            assign tick = run;
        end else begin : g_count
            localparam int DIV_W = $clog2(TICK_DIV);
            localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

            logic [DIV_W-1:0] div_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    div_q <= '0;
                end else if (!run || div_q == DIV_LAST) begin
                    div_q <= '0;
                end else begin
                    div_q <= div_q + 1'b1;
                end
            end

            assign tick = run && (div_q == DIV_LAST);
        end
    endgenerate

endmodule

// File: rtl/rps_fsm.sv
module rps_fsm
    import rps_pkg::*;
#(
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [PER_W-1:0] period,
    input  logic             tick,
    output logic             run,
    output logic             busy,
    output logic             fin,
    output logic             clk_en,
    output logic             per_rst
);

    localparam logic [PER_W-1:0] ONE = PER_W'(1);

    seq_state_t       state_q, state_d;
    logic [PER_W-1:0] rem_q, rem_d;
    logic [PER_W-1:0] eff_n;

    assign eff_n = (period == '0) ? ONE : period;

    always_comb begin
        state_d = state_q;
        rem_d   = rem_q;
        unique case (state_q)
            S_IDLE: begin
                if (start) state_d = S_GATE;
            end
            S_GATE: begin
                state_d = S_APPLY;
                rem_d   = eff_n;
            end
            S_APPLY: begin
                if (tick) begin
                    if (rem_q == ONE) begin
                        state_d = S_RELEASE;
                        rem_d   = eff_n;
                    end else begin
                        rem_d = rem_q - 1'b1;
                    end
                end
            end
            S_RELEASE: begin
                if (tick) begin
                    if (rem_q == ONE) state_d = S_UNGATE;
                    else              rem_d   = rem_q - 1'b1;
                end
            end
            S_UNGATE: begin
                state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            rem_q   <= '0;
        end else begin
            state_q <= state_d;
            rem_q   <= rem_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_en  <= 1'b1;
            per_rst <= 1'b0;
        end else begin
            clk_en  <= (state_d == S_IDLE) || (state_d == S_UNGATE);
            per_rst <= (state_d == S_APPLY);
        end
    end

    assign run  = (state_q == S_APPLY) || (state_q == S_RELEASE);
    assign busy = (state_q != S_IDLE);
    assign fin  = (state_q == S_UNGATE);

    AST_RST_CLK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        per_rst |-> !clk_en);                                           // R9
    AST_GATE_LEADS_RST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(per_rst) |-> $past(!clk_en));                             // R2
    AST_CLK_OFF_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(per_rst) |-> !clk_en);                                    // R4
    AST_BUSY_UNTIL_UNGATE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fin) |=> busy);                                       // R6

endmodule

// File: rtl/rst_pulse_seq.sv
module rst_pulse_seq
    import rps_pkg::*;
#(
    parameter int TICK_DIV = 25,
    parameter int PER_W    = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        clk_en,
    output logic        per_rst
);

    localparam int PER_MSB = PER_LSB + PER_W - 1;

    logic             run, tick, busy, fin, start;
    logic [PER_W-1:0] period_q;
    logic             done_q;
    logic             clr_done;

    assign start    = wr_en && wr_data[REQ_BIT] && !busy;
    assign clr_done = wr_en && wr_data[DONE_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_q <= '0;
        end else if (wr_en && !busy) begin
            period_q <= wr_data[PER_MSB:PER_LSB];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else if (fin) begin
            done_q <= 1'b1;
        end else if (clr_done) begin
            done_q <= 1'b0;
        end
    end

    always_comb begin
        rd_data                  = '0;
        rd_data[REQ_BIT]         = busy;
        rd_data[DONE_BIT]        = done_q;
        rd_data[PER_MSB:PER_LSB] = period_q;
    end

    rps_tick_div #(.TICK_DIV(TICK_DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    rps_fsm #(.PER_W(PER_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .period  (period_q),
        .tick    (tick),
        .run     (run),
        .busy    (busy),
        .fin     (fin),
        .clk_en  (clk_en),
        .per_rst (per_rst)
    );

    AST_PERIOD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(period_q));                                    // R7
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !clr_done) |=> done_q);                              // R8
    AST_DONE_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> done_q);                                                // R8

endmodule

// File: tb/tb_rst_pulse_seq.sv
module tb_rst_pulse_seq;

    localparam int TB_DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        clk_en;
    logic        per_rst;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    rst_pulse_seq #(.TICK_DIV(TB_DIV), .PER_W(8)) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .clk_en  (clk_en),
        .per_rst (per_rst)
    );

    function automatic int exp_cycles(input logic [7:0] n);
        return ((n == 8'd0) ? 1 : int'(n)) * TB_DIV;
    endfunction

    function automatic logic [31:0] mk_word(input logic [7:0] n, input bit req, input bit done);
        return {8'h00, n, 11'd0, done, 3'd0, req};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [31:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // Starts a sequence with period n and measures each phase at the ports.
    task automatic run_seq(input logic [7:0] n, input bit inject, input bit clr_at_end);
        int gate = 0;
        int app  = 0;
        int rel  = 0;
        int guard = 0;
        bit overlap = 1'b0;
        write_reg(mk_word(n, 1'b1, 1'b1));
        while (!clk_en && guard < 3000) begin
            if (per_rst) app++;
            else if (app == 0) gate++;
            else rel++;
            if (inject && rel == 2) check(rd_data[0] == 1'b1, "R7 req kept after write 0", int'(rd_data[0]), 1);
            if (inject && per_rst && app == 2) begin
                wr_en = 1'b1; wr_data = mk_word(8'h11, 1'b1, 1'b0);
            end else if (inject && !per_rst && rel == 1) begin
                wr_en = 1'b1; wr_data = 32'h0;
            end else begin
                wr_en = 1'b0;
            end
            guard++;
            @(negedge clk);
            if (per_rst && clk_en) overlap = 1'b1;
        end
        wr_en = 1'b0;
        check(!overlap, "R9 reset with clock running", int'(overlap), 0);
        check(gate == 1, "R2 gate cycles", gate, 1);
        check(app == exp_cycles(n), (n == 0) ? "R5 apply cycles" : "R3 apply cycles", app, exp_cycles(n));
        check(rel == exp_cycles(n), (n == 0) ? "R5 release cycles" : "R4 release cycles", rel, exp_cycles(n));
        check(rd_data[0] == 1'b1, "R6 req high in ungate", int'(rd_data[0]), 1);
        if (clr_at_end) begin
            wr_en = 1'b1; wr_data = mk_word(n, 1'b0, 1'b1);
        end
        @(negedge clk);
        wr_en = 1'b0;
        check(rd_data[0] == 1'b0, "R6 req cleared", int'(rd_data[0]), 0);
        check(rd_data[4] == 1'b1, clr_at_end ? "R8 set wins" : "R6 done set", int'(rd_data[4]), 1);
        check(rd_data[23:16] == n, "R7 period unchanged", int'(rd_data[23:16]), int'(n));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int seed_v;
        seed_v = $urandom(32'h5EED_0A17);
        repeat (3) @(negedge clk);
        // R1: reset state
        check(rd_data == 32'h0, "R1 rd_data", int'(rd_data), 0);
        check(clk_en == 1'b1, "R1 clk_en", int'(clk_en), 1);
        check(per_rst == 1'b0, "R1 per_rst", int'(per_rst), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: unused bits read zero, bit 0 = 0 starts nothing
        write_reg(32'hFF5A_FFEE);
        check(rd_data == 32'h005A_0000, "R10 unused bits", int'(rd_data), 32'h005A_0000);
        repeat (3) @(negedge clk);
        check(clk_en == 1'b1 && per_rst == 1'b0, "R10 no start", int'(clk_en), 1);

        // R5: zero period, R3/R4 maximum period
        run_seq(8'd0, 1'b0, 1'b0);
        run_seq(8'd255, 1'b0, 1'b0);

        // R7: writes during a running sequence
        run_seq(8'd3, 1'b1, 1'b0);
        repeat (20) begin
            @(negedge clk);
            if (!clk_en || per_rst) begin
                check(1'b0, "R7 second sequence", 1, 0);
                break;
            end
        end
        check(clk_en == 1'b1, "R7 idle after ignored request", int'(clk_en), 1);

        // R8: write 0 keeps done, write 1 clears it
        write_reg(mk_word(8'd3, 1'b0, 1'b0));
        check(rd_data[4] == 1'b1, "R8 done sticky", int'(rd_data[4]), 1);
        write_reg(mk_word(8'd3, 1'b0, 1'b1));
        check(rd_data[4] == 1'b0, "R8 done cleared", int'(rd_data[4]), 0);

        // R8: clear in the completion cycle
        run_seq(8'd1, 1'b0, 1'b1);

        // Random periods
        for (int i = 0; i < 10; i++) begin
            logic [7:0] n;
            n = 8'($urandom);
            run_seq(n, 1'b0, 1'b0);
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule